// File: doc/BRIEF.md
# Serial Audio Link Reset and Wake Controller

This block is the codec-side control logic that decides when the serial audio link is running. It tells apart three kinds of reset and handles the codec-initiated wake request. A cold reset comes from an asynchronous active-low reset pin and clears both the link logic and the register file. A warm reset comes from the frame-sync line being held high while the bit clock is stopped, and it restarts the link without touching the registers. A register reset comes from any write to register address zero and clears only the registers.

Every timing decision runs on a free-running local clock. The reason is that the bit clock is absent at exactly the moments when a warm reset or a wake must be recognised. On a primary codec the block gates the bit clock output. It keeps that clock stopped after a warm reset until the sync line has been seen low again. On a secondary codec the bit clock is only observed and never driven. To request a wake, the block raises the serial data return line and holds it high until a warm or cold reset arrives.

Top module: `ac_link_rst_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, `link_state` reads 0 and `bclk_run`, `sdata_wake`, `link_rst` and `reg_rst` all read 0 while `link_rst_n` is high. The state encoding is OFF=0, ACTIVE=1, WAKE_PENDING=2, and the value 3 never appears.
- R2: When `link_rst_n` is held low for at least COLD_MIN_CYC local clock cycles and then released, `link_rst` and `reg_rst` pulse high together for exactly one cycle. After that, `link_state` becomes ACTIVE, `bclk_run` equals `is_primary` and `sdata_wake` is 0.
- R3: A low pulse on `link_rst_n` shorter than COLD_MIN_CYC produces no `link_rst` pulse and no `reg_rst` pulse after release. It leaves `link_state` and `sdata_wake` unchanged.
- R4: `reg_rst` is high whenever `link_rst_n` is low, without waiting for a clock edge.
- R5: A cycle with `reg_wr` high and `reg_addr` equal to 0 produces a one-cycle `reg_rst` pulse in the following cycle. `link_state`, `bclk_run` and `sdata_wake` are unchanged. A write to any other address produces no pulse.
- R6: In ACTIVE, a `link_down_req` moves the state to OFF and drops `bclk_run` in the next cycle.
- R7: Outside ACTIVE, with the bit clock absent, `sync_in` held high for at least 1 µs (WARM_NS, counted on the local clock) and then returned low makes the state ACTIVE. This happens without any `reg_rst` or `link_rst` pulse. A shorter high level leaves the state unchanged.
- R8: After a warm reset has been recognised, `bclk_run` stays 0 and the state stays unchanged for as long as `sync_in` is still high. The link restarts only after `sync_in` has been sampled low.
- R9: In OFF, `wake_req` moves the state to WAKE_PENDING (2) and sets `sdata_wake`. `sdata_wake` then stays high until a warm or cold reset completes, and at that point it returns to 0.
- R10: In ACTIVE, `wake_req` is ignored: `sdata_wake` stays 0 and the state stays ACTIVE.
- R11: With `is_primary` low, `bclk_run` is never asserted and bit clock absence is taken from `bclk_alive`. A high `sync_in` while `bclk_alive` is 1 is not a warm reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock |
| rst | input | 1 | Synchronous active-high reset of the controller |
| link_rst_n | input | 1 | Asynchronous active-low link reset pin |
| sync_in | input | 1 | Frame-sync line from the link controller |
| bclk_alive | input | 1 | Bit clock activity indication (used when secondary) |
| is_primary | input | 1 | 1 when this codec sources the bit clock |
| link_down_req | input | 1 | Request to put the link into low power (stop clock) |
| wake_req | input | 1 | Codec event asking for a wake |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register write address |
| bclk_run | output | 1 | Bit clock output gate |
| sdata_wake | output | 1 | Drives the serial data return line high for wake |
| reg_rst | output | 1 | Register file reset to defaults |
| link_rst | output | 1 | One-cycle link logic reset after a cold reset |
| link_state | output | 2 | 0 OFF, 1 ACTIVE, 2 WAKE_PENDING |

## Verification
Two things can land in the same cycle: a warm reset completes, and a register write to address zero is taken. When both happen, the state must go to ACTIVE and the registers must be reset, but the link logic must not be. The bench drops `sync_in` at the end of a long high period and times a write to address zero so that it lands on the same edge where the warm reset completes. The scoreboard must then see exactly one pulse with `reg_rst` high and `link_rst` low, and the state and clock gate must read ACTIVE and running afterwards.

// File: rtl/rstw_pkg.sv
package rstw_pkg;
  typedef enum logic [1:0] {
    LNK_OFF    = 2'd0,
    LNK_ACTIVE = 2'd1,
    LNK_WAKE   = 2'd2
  } lnk_state_e;
endpackage

// File: rtl/rstw_sync.sv
// Two-flop synchroniser, one chain per bit, with a per-bit reset value.
module rstw_sync #(
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d[i];
        s2_q <= s1_q;
      end
    end
    assign q[i] = s2_q;
  end
endmodule

// File: rtl/rstw_width_meter.sv
// Counts consecutive cycles of a level; met is high once LIMIT cycles are seen.
module rstw_width_meter #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic met
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !level) cnt_q <= '0;
    else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign met = (cnt_q == TOP);
endmodule

// File: rtl/rstw_link_seq.sv
// Link state sequencer: resolves cold, warm, register reset and wake events.
module rstw_link_seq
  import rstw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cold_fire,
  input  logic       warm_met,
  input  logic       sync_s,
  input  logic       is_primary,
  input  logic       link_down_req,
  input  logic       wake_req,
  input  logic       reg_hit,
  output lnk_state_e state,
  output logic       bclk_run,
  output logic       sdata_wake,
  output logic       reg_rst_q,
  output logic       link_rst_q
);
  lnk_state_e st_q, st_d;
  logic bclk_q, bclk_d, wake_q, wake_d, armed_q, armed_d;
  logic rr_d, lr_d, warm_fire;

  always_comb begin
    st_d      = st_q;
    bclk_d    = bclk_q;
    wake_d    = wake_q;
    armed_d   = armed_q;
    rr_d      = reg_hit;
    lr_d      = 1'b0;
    warm_fire = armed_q & ~sync_s;
    if (cold_fire) begin
      st_d    = LNK_ACTIVE;
      bclk_d  = 1'b1;
      wake_d  = 1'b0;
      armed_d = 1'b0;
      rr_d    = 1'b1;
      lr_d    = 1'b1;
    end else if (warm_fire) begin
      st_d    = LNK_ACTIVE;
      bclk_d  = 1'b1;
      wake_d  = 1'b0;
      armed_d = 1'b0;
    end else begin
      if (warm_met) armed_d = 1'b1;
      case (st_q)
        LNK_ACTIVE: if (link_down_req) begin
          st_d   = LNK_OFF;
          bclk_d = 1'b0;
        end
        LNK_OFF: if (wake_req) begin
          st_d   = LNK_WAKE;
          wake_d = 1'b1;
        end
        default: ;
      endcase
    end
    bclk_d = bclk_d & is_primary;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= LNK_OFF;
      bclk_q     <= 1'b0;
      wake_q     <= 1'b0;
      armed_q    <= 1'b0;
      reg_rst_q  <= 1'b0;
      link_rst_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      bclk_q     <= bclk_d;
      wake_q     <= wake_d;
      armed_q    <= armed_d;
      reg_rst_q  <= rr_d;
      link_rst_q <= lr_d;
    end
  end

  assign state      = st_q;
  assign bclk_run   = bclk_q;
  assign sdata_wake = wake_q;
endmodule

// File: rtl/ac_link_rst_ctrl.sv
module ac_link_rst_ctrl
  import rstw_pkg::*;
#(
  parameter int CLK_HZ       = 125_000_000,
  parameter int WARM_NS      = 1000,
  parameter int COLD_MIN_CYC = 16,
  parameter int AW           = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          link_rst_n,
  input  logic          sync_in,
  input  logic          bclk_alive,
  input  logic          is_primary,
  input  logic          link_down_req,
  input  logic          wake_req,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  output logic          bclk_run,
  output logic          sdata_wake,
  output logic          reg_rst,
  output logic          link_rst,
  output logic [1:0]    link_state
);
  localparam longint WARM_RAW = ((longint'(CLK_HZ) / 1000) * WARM_NS + 999_999) / 1_000_000;
  localparam int     WARM_CYC = (WARM_RAW < 1) ? 1 : int'(WARM_RAW);

  logic [2:0] raw_in, synced;
  logic       sync_s, pin_n_s, alive_s;
  logic       cold_met, cold_fire, warm_level, warm_met, clk_absent, reg_hit;
  logic       reg_rst_q;
  lnk_state_e state;

  assign raw_in = {bclk_alive, link_rst_n, sync_in};

  rstw_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(synced)
  );
  assign sync_s  = synced[0];
  assign pin_n_s = synced[1];
  assign alive_s = synced[2];

  rstw_width_meter #(.LIMIT(COLD_MIN_CYC)) u_cold (
    .clk(clk), .rst(rst), .level(~pin_n_s), .met(cold_met)
  );
  assign cold_fire = pin_n_s & cold_met;

  assign clk_absent = is_primary ? ~bclk_run : ~alive_s;
  assign warm_level = sync_s & clk_absent & (state != LNK_ACTIVE);

  rstw_width_meter #(.LIMIT(WARM_CYC)) u_warm (
    .clk(clk), .rst(rst), .level(warm_level), .met(warm_met)
  );

  assign reg_hit = reg_wr && (reg_addr == '0);

  rstw_link_seq u_seq (
    .clk(clk), .rst(rst), .cold_fire(cold_fire), .warm_met(warm_met),
    .sync_s(sync_s), .is_primary(is_primary), .link_down_req(link_down_req),
    .wake_req(wake_req), .reg_hit(reg_hit), .state(state),
    .bclk_run(bclk_run), .sdata_wake(sdata_wake), .reg_rst_q(reg_rst_q),
    .link_rst_q(link_rst)
  );

  assign reg_rst    = reg_rst_q | ~link_rst_n;
  assign link_state = state;
endmodule

// File: rtl/ac_link_rst_ctrl_chk.sv
module ac_link_rst_ctrl_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          link_rst_n,
  input logic          is_primary,
  input logic          wake_req,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic          sync_s,
  input logic          bclk_run,
  input logic          sdata_wake,
  input logic          reg_rst,
  input logic          link_rst,
  input logic [1:0]    link_state
);
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    link_state != 2'd3);  // R1
  AST_LINK_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    link_rst |=> !link_rst);  // R2
  AST_PIN_FORCES_REG_RST: assert property (@(posedge clk) disable iff (rst)
    !link_rst_n |-> reg_rst);  // R4
  AST_ADDR0_WRITE_STROBE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == '0) |=> reg_rst);  // R5
  AST_RESTART_AFTER_SYNC_LOW: assert property (@(posedge clk) disable iff (rst)
    ($rose(bclk_run) && !link_rst) |-> !$past(sync_s));  // R8
  AST_WAKE_CLEARS_ON_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(sdata_wake) |-> link_state == 2'd1);  // R9
  AST_WAKE_IGNORED_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (link_state == 2'd1 && wake_req) |=> !sdata_wake);  // R10
  AST_SECONDARY_NO_CLOCK: assert property (@(posedge clk) disable iff (rst)
    bclk_run |-> $past(is_primary));  // R11
endmodule

bind ac_link_rst_ctrl ac_link_rst_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .link_rst_n(link_rst_n), .is_primary(is_primary),
  .wake_req(wake_req), .reg_wr(reg_wr), .reg_addr(reg_addr), .sync_s(sync_s),
  .bclk_run(bclk_run), .sdata_wake(sdata_wake), .reg_rst(reg_rst),
  .link_rst(link_rst), .link_state(link_state)
);

// File: tb/ac_link_rst_ctrl_test.sv
`timescale 1ns/1ps
module ac_link_rst_ctrl_test;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic link_rst_n = 1'b1, sync_in = 1'b0, bclk_alive = 1'b0, is_primary = 1'b1;
  logic link_down_req = 1'b0, wake_req = 1'b0, reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic bclk_run, sdata_wake, reg_rst, link_rst;
  logic [1:0] link_state;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  logic [1:0] exp_q[$];

  always #4 clk = ~clk;

  ac_link_rst_ctrl #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .link_rst_n(link_rst_n), .sync_in(sync_in),
    .bclk_alive(bclk_alive), .is_primary(is_primary), .link_down_req(link_down_req),
    .wake_req(wake_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .bclk_run(bclk_run), .sdata_wake(sdata_wake), .reg_rst(reg_rst),
    .link_rst(link_rst), .link_state(link_state)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic pulse_down();
    link_down_req = 1'b1; tick(1); link_down_req = 1'b0; tick(2);
  endtask

  task automatic pulse_wake();
    wake_req = 1'b1; tick(1); wake_req = 1'b0; tick(2);
  endtask

  // Driver: pushes the reset strobe pattern {link_rst, reg_rst} it expects
  task automatic write_reg(input logic [AW-1:0] a);
    if (a == '0) exp_q.push_back(2'b01);
    reg_addr = a; reg_wr = 1'b1; tick(1); reg_wr = 1'b0; tick(3);
  endtask

  task automatic pin_low(input int n, input bit qualifies);
    if (qualifies) exp_q.push_back(2'b11);
    link_rst_n = 1'b0;
    tick(n);
    link_rst_n = 1'b1;
    tick(10);
  endtask

  // Monitor: pops expected strobe pattern whenever a clocked strobe appears
  always @(negedge clk) begin
    if (!rst && link_rst_n && (reg_rst || link_rst)) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2/R3/R5/R7 unexpected strobe actual=%0d expected=none",
                 {link_rst, reg_rst});
      end else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        if ({link_rst, reg_rst} != e) begin
          n_fail++;
          $display("FAIL R2/R5/R7 strobe actual=%0d expected=%0d", {link_rst, reg_rst}, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(3);
    // R1 reset state
    check("R1 state", link_state, 0);
    check("R1 bclk_run", bclk_run, 0);
    check("R1 sdata_wake", sdata_wake, 0);
    check("R1 reg_rst", reg_rst, 0);
    check("R1 link_rst", link_rst, 0);

    // R2 / R4 cold reset as primary
    exp_q.push_back(2'b11);
    link_rst_n = 1'b0;
    tick(3);
    check("R4 reg_rst while pin low", reg_rst, 1);
    tick(37);
    link_rst_n = 1'b1;
    tick(10);
    check("R2 state after cold", link_state, 1);
    check("R2 bclk_run primary", bclk_run, 1);
    check("R2 sdata_wake", sdata_wake, 0);

    // R5 register reset, other address ignored
    write_reg(7'd0);
    write_reg(7'd5);
    check("R5 state unchanged", link_state, 1);
    check("R5 bclk unchanged", bclk_run, 1);

    // R10 wake ignored when active
    pulse_wake();
    check("R10 sdata_wake", sdata_wake, 0);
    check("R10 state", link_state, 1);

    // R6 low power
    pulse_down();
    check("R6 state off", link_state, 0);
    check("R6 bclk stopped", bclk_run, 0);

    // R7 short sync high ignored
    sync_in = 1'b1; tick(50); sync_in = 1'b0; tick(10);
    check("R7 short sync ignored", link_state, 0);

    // R9 wake request
    pulse_wake();
    check("R9 state pending", link_state, 2);
    check("R9 sdata_wake set", sdata_wake, 1);

    // R3 short reset pulse ignored
    pin_low(5, 0);
    check("R3 state kept", link_state, 2);
    check("R3 wake kept", sdata_wake, 1);

    // R7/R8/R9 warm reset, coinciding with address-0 write
    sync_in = 1'b1;
    tick(190);
    check("R8 bclk held while sync high", bclk_run, 0);
    check("R8 state held while sync high", link_state, 2);
    check("R9 wake held", sdata_wake, 1);
    sync_in = 1'b0;
    tick(2);
    exp_q.push_back(2'b01);
    reg_addr = '0; reg_wr = 1'b1; tick(1); reg_wr = 1'b0;
    tick(10);
    check("R7 warm state active", link_state, 1);
    check("R7 bclk restarted", bclk_run, 1);
    check("R9 wake cleared by warm", sdata_wake, 0);

    // R11 secondary behaviour
    is_primary = 1'b0;
    tick(3);
    check("R11 secondary bclk off", bclk_run, 0);
    pulse_down();
    check("R11 state off", link_state, 0);
    bclk_alive = 1'b1;
    sync_in = 1'b1; tick(200); sync_in = 1'b0; tick(10);
    check("R11 no warm with clock alive", link_state, 0);
    bclk_alive = 1'b0;
    tick(3);
    sync_in = 1'b1; tick(200); sync_in = 1'b0; tick(10);
    check("R11 warm with clock absent", link_state, 1);
    check("R11 bclk never driven", bclk_run, 0);

    // R2 cold reset clears a pending wake
    is_primary = 1'b1;
    pulse_down();
    pulse_wake();
    check("R9 pending again", sdata_wake, 1);
    pin_low(30, 1);
    check("R2 cold clears wake", sdata_wake, 0);
    check("R2 cold state", link_state, 1);
    check("R2 cold bclk", bclk_run, 1);

    tick(5);
    check("R2/R5/R7 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule